// File: doc/BRIEF.md
# NaN and Special Operand Selector

This block sits at the front of a two-input floating-point operation. It takes two operands in unpacked form, each a class code, a sign, an unbiased exponent and a normalized mantissa with the leading one at the top bit. It decides whether the result is already fixed by the rules for not-a-number operands. If it is, the block emits the chosen operand as the result and raises a bypass flag so the downstream arithmetic result is discarded. A chosen signalling NaN leaves as a quiet NaN and raises the invalid-operation flag.

The block also emits an ordered operand pair for the datapath. The operand with the higher priority, found by one unsigned comparison of the class codes, goes in the high slot. When the two operands tie, the second operand takes the high slot. A subtract request flips the sign of the second operand before any of this happens. All outputs are registered one cycle after a valid input.

The class codes are three bits, read as signed values: zero is 3'b000, a finite number is 3'b001, infinity is 3'b010, a quiet NaN is 3'b111 (-1) and a signalling NaN is 3'b110 (-2). Read as unsigned values, these codes rank quiet NaN, then signalling NaN, then infinity, then number, then zero.

Top module: `nan_select`

## Requirements
- R1: While rst_n is low, and in the first cycle after its release, out_valid, res_bypass and res_invalid are 0.
- R2: out_valid is 1 exactly in the cycle after a cycle with in_valid at 1. All other outputs change only then.
- R3: When both operands are signalling NaNs (class 3'b110), the result is operand b converted to quiet.
- R4: When exactly one operand is a signalling NaN, the result is that operand converted to quiet, whatever the other operand is. Converting sets the class to 3'b111 and sets mantissa bit MANT_W-2 (weight 0.5). Sign, exponent and the other mantissa bits are kept.
- R5: With no signalling NaN present, two quiet NaNs (class 3'b111) give operand b unchanged. A single quiet NaN gives that operand unchanged.
- R6: res_invalid is 1 exactly when at least one input operand is a signalling NaN.
- R7: res_bypass is 1 exactly when at least one input operand is a NaN of either kind.
- R8: The high slot holds operand a when the class code of a, read unsigned, is strictly greater than that of b. Otherwise the high slot holds operand b. The low slot holds the other operand. Neither slot is modified, even when it holds a NaN.
- R9: When in_sub is 1, the sign of operand b is inverted before selection and ordering. This affects both the result and the pair.
- R10: When neither operand is a NaN, res_bypass is 0 and the result equals the high-slot operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| in_sub | input | 1 | Subtract request: invert sign of operand b |
| a_cls | input | 3 | Operand a class code |
| a_sign | input | 1 | Operand a sign |
| a_exp | input | EXP_W | Operand a exponent |
| a_mant | input | MANT_W | Operand a mantissa |
| b_cls | input | 3 | Operand b class code |
| b_sign | input | 1 | Operand b sign |
| b_exp | input | EXP_W | Operand b exponent |
| b_mant | input | MANT_W | Operand b mantissa |
| out_valid | output | 1 | Outputs valid |
| res_cls | output | 3 | Result class code |
| res_sign | output | 1 | Result sign |
| res_exp | output | EXP_W | Result exponent |
| res_mant | output | MANT_W | Result mantissa |
| res_bypass | output | 1 | Result fixed by NaN rules |
| res_invalid | output | 1 | Invalid-operation flag |
| lo_cls | output | 3 | Low-slot class code |
| lo_sign | output | 1 | Low-slot sign |
| lo_exp | output | EXP_W | Low-slot exponent |
| lo_mant | output | MANT_W | Low-slot mantissa |
| hi_cls | output | 3 | High-slot class code |
| hi_sign | output | 1 | High-slot sign |
| hi_exp | output | EXP_W | High-slot exponent |
| hi_mant | output | MANT_W | High-slot mantissa |

## Verification
The block holds no state beyond one output register stage. Any wrong decision appears at the ports in the cycle right after the offending input.

- A wrong NaN priority shows as the wrong operand in the result.
- A swapped tie-break shows as operand a in the high slot when the classes are equal.
- A missing or misplaced quiet bit shows in res_mant or res_cls.
- A missed subtract flip shows as a wrong sign on whichever slot carries operand b.

Directed vectors cover each pairing of NaN kinds in both orders. Random class pairs then sweep the rest of the 25 combinations, with and without subtract.

// File: rtl/nansel_pkg.sv
// Package: class codes shared by the selector modules and its checker.
// Assumes the three-bit class code is read as signed by users but ordered
// as unsigned for priority.
package nansel_pkg;
    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_ZERO = 3'b000,
        CLS_NUM  = 3'b001,
        CLS_INF  = 3'b010,
        CLS_SNAN = 3'b110,
        CLS_QNAN = 3'b111
    } op_class_e;
endpackage

// File: rtl/nansel_decode.sv
// Module: decodes one class code into NaN-kind flags.
// Assumes codes other than the two NaN codes are never NaNs.
module nansel_decode
    import nansel_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    output logic             is_snan,
    output logic             is_qnan
);
    // Flag the two NaN encodings.
    always_comb begin
        is_snan = (cls == CLS_SNAN);
        is_qnan = (cls == CLS_QNAN);
    end
endmodule

// File: rtl/nansel_order.sv
// Module: orders two packed operands by an unsigned class comparison.
// Operand a reaches the high slot only when its class is strictly greater;
// ties send operand b high. Assumes the class occupies the top bits of
// each packed operand.
module nansel_order
    import nansel_pkg::*;
#(
    parameter int OP_W = 36
) (
    input  logic [OP_W-1:0] a_vec,
    input  logic [OP_W-1:0] b_vec,
    output logic [OP_W-1:0] lo_vec,
    output logic [OP_W-1:0] hi_vec
);
    logic [CLS_W-1:0] a_key;
    logic [CLS_W-1:0] b_key;
    logic             a_above;

    // Extract class keys and compare them unsigned.
    always_comb begin
        a_key   = a_vec[OP_W-1 -: CLS_W];
        b_key   = b_vec[OP_W-1 -: CLS_W];
        a_above = (a_key > b_key);
    end

    // Route the operands into the two slots.
    always_comb begin
        if (a_above) begin
            hi_vec = a_vec;
            lo_vec = b_vec;
        end else begin
            hi_vec = b_vec;
            lo_vec = a_vec;
        end
    end
endmodule

// File: rtl/nansel_pick.sv
// Module: applies the NaN precedence rules to the NaN flags of both
// operands. Signalling NaNs outrank quiet NaNs; between two NaNs of the
// same kind operand b wins. Assumes each flag pair is mutually exclusive.
module nansel_pick (
    input  logic a_snan,
    input  logic a_qnan,
    input  logic b_snan,
    input  logic b_qnan,
    output logic use_nan,
    output logic take_a,
    output logic make_quiet,
    output logic any_snan
);
    // Decide which NaN, if any, becomes the result.
    always_comb begin
        any_snan   = a_snan | b_snan;
        use_nan    = any_snan | a_qnan | b_qnan;
        make_quiet = any_snan;
        if (any_snan) begin
            take_a = a_snan & ~b_snan;
        end else begin
            take_a = a_qnan & ~b_qnan;
        end
    end
endmodule

// File: rtl/nan_select.sv
// Module: top of the NaN and special operand selector.
// Applies the subtract sign flip, decodes both operands, orders them, picks
// the NaN result if any, and registers every output one cycle after
// in_valid. Assumes normalized mantissas with the leading one at the top.
module nan_select
    import nansel_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int MANT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sub,
    input  logic [2:0]        a_cls,
    input  logic              a_sign,
    input  logic [EXP_W-1:0]  a_exp,
    input  logic [MANT_W-1:0] a_mant,
    input  logic [2:0]        b_cls,
    input  logic              b_sign,
    input  logic [EXP_W-1:0]  b_exp,
    input  logic [MANT_W-1:0] b_mant,
    output logic              out_valid,
    output logic [2:0]        res_cls,
    output logic              res_sign,
    output logic [EXP_W-1:0]  res_exp,
    output logic [MANT_W-1:0] res_mant,
    output logic              res_bypass,
    output logic              res_invalid,
    output logic [2:0]        lo_cls,
    output logic              lo_sign,
    output logic [EXP_W-1:0]  lo_exp,
    output logic [MANT_W-1:0] lo_mant,
    output logic [2:0]        hi_cls,
    output logic              hi_sign,
    output logic [EXP_W-1:0]  hi_exp,
    output logic [MANT_W-1:0] hi_mant
);
    localparam int OP_W = CLS_W + 1 + EXP_W + MANT_W;
    localparam int QBIT = MANT_W - 2;
    localparam int NOPS = 2;

    logic [OP_W-1:0] op_vec [NOPS];
    logic [NOPS-1:0] snan_f;
    logic [NOPS-1:0] qnan_f;
    logic [OP_W-1:0] lo_vec;
    logic [OP_W-1:0] hi_vec;
    logic            use_nan;
    logic            take_a;
    logic            make_quiet;
    logic            any_snan;
    logic [OP_W-1:0] nan_vec;
    logic [OP_W-1:0] res_next;

    logic [OP_W-1:0] res_q;
    logic [OP_W-1:0] lo_q;
    logic [OP_W-1:0] hi_q;

    // Pack both operands, flipping the sign of b on a subtract request.
    always_comb begin
        op_vec[0] = {a_cls, a_sign, a_exp, a_mant};
        op_vec[1] = {b_cls, b_sign ^ in_sub, b_exp, b_mant};
    end

    // One class decoder per operand.
    for (genvar gi = 0; gi < NOPS; gi++) begin : g_dec
        nansel_decode u_dec (
            .cls     (op_vec[gi][OP_W-1 -: CLS_W]),
            .is_snan (snan_f[gi]),
            .is_qnan (qnan_f[gi])
        );
    end

    nansel_order #(.OP_W(OP_W)) u_order (
        .a_vec  (op_vec[0]),
        .b_vec  (op_vec[1]),
        .lo_vec (lo_vec),
        .hi_vec (hi_vec)
    );

    nansel_pick u_pick (
        .a_snan     (snan_f[0]),
        .a_qnan     (qnan_f[0]),
        .b_snan     (snan_f[1]),
        .b_qnan     (qnan_f[1]),
        .use_nan    (use_nan),
        .take_a     (take_a),
        .make_quiet (make_quiet),
        .any_snan   (any_snan)
    );

    // Build the NaN result, quieting it when a signalling NaN was chosen.
    always_comb begin
        nan_vec = take_a ? op_vec[0] : op_vec[1];
        if (make_quiet) begin
            nan_vec[OP_W-1 -: CLS_W] = CLS_QNAN;
            nan_vec[QBIT]            = 1'b1;
        end
        res_next = use_nan ? nan_vec : hi_vec;
    end

    // Output register stage, loaded on each valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            res_bypass  <= 1'b0;
            res_invalid <= 1'b0;
            res_q       <= '0;
            lo_q        <= '0;
            hi_q        <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_bypass  <= use_nan;
                res_invalid <= any_snan;
                res_q       <= res_next;
                lo_q        <= lo_vec;
                hi_q        <= hi_vec;
            end
        end
    end

    // Unpack the registered operands onto the ports.
    always_comb begin
        {res_cls, res_sign, res_exp, res_mant} = res_q;
        {lo_cls, lo_sign, lo_exp, lo_mant}     = lo_q;
        {hi_cls, hi_sign, hi_exp, hi_mant}     = hi_q;
    end
endmodule

// File: rtl/nansel_checker.sv
// Module: port-level properties of nan_select, bound to every instance.
// Assumes the one-cycle output latency of the top module.
module nansel_checker
    import nansel_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int MANT_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        a_cls,
    input logic [2:0]        b_cls,
    input logic              out_valid,
    input logic [2:0]        res_cls,
    input logic              res_sign,
    input logic [EXP_W-1:0]  res_exp,
    input logic [MANT_W-1:0] res_mant,
    input logic              res_bypass,
    input logic              res_invalid,
    input logic [2:0]        lo_cls,
    input logic [2:0]        hi_cls,
    input logic              hi_sign,
    input logic [EXP_W-1:0]  hi_exp,
    input logic [MANT_W-1:0] hi_mant
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_quiet_on_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && res_invalid) |-> (res_cls == CLS_QNAN && res_mant[MANT_W-2]));

    assert_invalid_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (res_invalid == ($past(a_cls) == CLS_SNAN || $past(b_cls) == CLS_SNAN)));

    assert_bypass_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (res_bypass == ($past(a_cls) == CLS_SNAN || $past(b_cls) == CLS_SNAN
                                  || $past(a_cls) == CLS_QNAN || $past(b_cls) == CLS_QNAN)));

    assert_pair_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (hi_cls >= lo_cls));

    assert_plain_passes_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !res_bypass) |->
        (res_cls == hi_cls && res_sign == hi_sign && res_exp == hi_exp && res_mant == hi_mant));
endmodule

bind nan_select nansel_checker #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_nansel_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .a_cls       (a_cls),
    .b_cls       (b_cls),
    .out_valid   (out_valid),
    .res_cls     (res_cls),
    .res_sign    (res_sign),
    .res_exp     (res_exp),
    .res_mant    (res_mant),
    .res_bypass  (res_bypass),
    .res_invalid (res_invalid),
    .lo_cls      (lo_cls),
    .hi_cls      (hi_cls),
    .hi_sign     (hi_sign),
    .hi_exp      (hi_exp),
    .hi_mant     (hi_mant)
);

// File: tb/test_nan_select.sv
module test_nan_select;
    localparam int EXP_W  = 8;
    localparam int MANT_W = 24;
    localparam int OP_W   = 3 + 1 + EXP_W + MANT_W;
    localparam logic [2:0] C_ZERO = 3'b000, C_NUM = 3'b001, C_INF = 3'b010,
                           C_SNAN = 3'b110, C_QNAN = 3'b111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sub = 1'b0;
    logic [2:0] a_cls = '0, b_cls = '0;
    logic a_sign = 1'b0, b_sign = 1'b0;
    logic [EXP_W-1:0] a_exp = '0, b_exp = '0;
    logic [MANT_W-1:0] a_mant = '0, b_mant = '0;
    logic out_valid, res_sign, lo_sign, hi_sign, res_bypass, res_invalid;
    logic [2:0] res_cls, lo_cls, hi_cls;
    logic [EXP_W-1:0] res_exp, lo_exp, hi_exp;
    logic [MANT_W-1:0] res_mant, lo_mant, hi_mant;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    nan_select #(.EXP_W(EXP_W), .MANT_W(MANT_W)) i_nan_select (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub),
        .a_cls(a_cls), .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
        .b_cls(b_cls), .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
        .out_valid(out_valid),
        .res_cls(res_cls), .res_sign(res_sign), .res_exp(res_exp), .res_mant(res_mant),
        .res_bypass(res_bypass), .res_invalid(res_invalid),
        .lo_cls(lo_cls), .lo_sign(lo_sign), .lo_exp(lo_exp), .lo_mant(lo_mant),
        .hi_cls(hi_cls), .hi_sign(hi_sign), .hi_exp(hi_exp), .hi_mant(hi_mant)
    );

    task automatic check(input string req, input logic [OP_W-1:0] act, input logic [OP_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [OP_W-1:0] quieten(input logic [OP_W-1:0] v);
        logic [OP_W-1:0] r = v;
        r[OP_W-1 -: 3] = C_QNAN;
        r[MANT_W-2] = 1'b1;
        return r;
    endfunction

    function automatic logic [OP_W-1:0] ref_hi(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
        return (a[OP_W-1 -: 3] > b[OP_W-1 -: 3]) ? a : b;
    endfunction

    function automatic logic [OP_W-1:0] ref_lo(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
        return (a[OP_W-1 -: 3] > b[OP_W-1 -: 3]) ? b : a;
    endfunction

    function automatic logic [OP_W-1:0] ref_res(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
        logic as = a[OP_W-1 -: 3] == C_SNAN, bs = b[OP_W-1 -: 3] == C_SNAN;
        logic aq = a[OP_W-1 -: 3] == C_QNAN, bq = b[OP_W-1 -: 3] == C_QNAN;
        if (bs) return quieten(b);
        if (as) return quieten(a);
        if (bq) return b;
        if (aq) return a;
        return ref_hi(a, b);
    endfunction

    function automatic string res_tag(input logic [2:0] ac, input logic [2:0] bc);
        if (ac == C_SNAN && bc == C_SNAN) return "R3";
        if (ac == C_SNAN || bc == C_SNAN) return "R4";
        if (ac == C_QNAN || bc == C_QNAN) return "R5";
        return "R10";
    endfunction

    // Drive one operand pair, then compare every output one cycle later.
    task automatic run(input logic [2:0] ac, input logic as, input logic [EXP_W-1:0] ae,
                       input logic [MANT_W-1:0] am, input logic [2:0] bc, input logic bs,
                       input logic [EXP_W-1:0] be, input logic [MANT_W-1:0] bm, input logic sub,
                       input string sub_tag);
        logic [OP_W-1:0] va, vb;
        @(negedge clk);
        a_cls = ac; a_sign = as; a_exp = ae; a_mant = am;
        b_cls = bc; b_sign = bs; b_exp = be; b_mant = bm;
        in_sub = sub; in_valid = 1'b1;
        va = {ac, as, ae, am};
        vb = {bc, bs ^ sub, be, bm};
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", {{(OP_W-1){1'b0}}, out_valid}, 1);
        check(sub ? sub_tag : res_tag(ac, bc),
              {res_cls, res_sign, res_exp, res_mant}, ref_res(va, vb));
        check("R6", {{(OP_W-1){1'b0}}, res_invalid},
              {{(OP_W-1){1'b0}}, (ac == C_SNAN || bc == C_SNAN)});
        check("R7", {{(OP_W-1){1'b0}}, res_bypass},
              {{(OP_W-1){1'b0}}, (ac == C_SNAN || bc == C_SNAN || ac == C_QNAN || bc == C_QNAN)});
        check(sub ? sub_tag : "R8", {hi_cls, hi_sign, hi_exp, hi_mant}, ref_hi(va, vb));
        check(sub ? sub_tag : "R8", {lo_cls, lo_sign, lo_exp, lo_mant}, ref_lo(va, vb));
    endtask

    initial begin : watchdog
        #(2_000_000);
        bad++; total++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        logic [2:0] codes [5];
        codes[0] = C_ZERO; codes[1] = C_NUM; codes[2] = C_INF; codes[3] = C_SNAN; codes[4] = C_QNAN;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset state while in reset
        check("R1", {{(OP_W-3){1'b0}}, out_valid, res_bypass, res_invalid}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {{(OP_W-3){1'b0}}, out_valid, res_bypass, res_invalid}, '0);

        // R3: two signalling NaNs
        run(C_SNAN, 1'b1, 8'h11, 24'h800001, C_SNAN, 1'b0, 8'h22, 24'h800002, 1'b0, "R9");
        // R4: single signalling NaN in each position, partner quiet NaN
        run(C_SNAN, 1'b0, 8'h33, 24'h812345, C_QNAN, 1'b1, 8'h44, 24'hC00000, 1'b0, "R9");
        run(C_QNAN, 1'b0, 8'h55, 24'hC00001, C_SNAN, 1'b1, 8'h66, 24'h80ABCD, 1'b0, "R9");
        run(C_INF,  1'b0, 8'h00, 24'h800000, C_SNAN, 1'b0, 8'h07, 24'hBFFFFF, 1'b0, "R9");
        // R5: two quiet NaNs, and a quiet NaN against infinity
        run(C_QNAN, 1'b1, 8'h01, 24'hC0000A, C_QNAN, 1'b0, 8'h02, 24'hC0000B, 1'b0, "R9");
        run(C_QNAN, 1'b1, 8'h03, 24'h80000C, C_INF,  1'b0, 8'h04, 24'h800000, 1'b0, "R9");
        // R8/R10: ordering, including tie sending b high
        run(C_INF,  1'b1, 8'h10, 24'h800000, C_NUM,  1'b0, 8'h20, 24'h912345, 1'b0, "R9");
        run(C_NUM,  1'b0, 8'h30, 24'hA00000, C_NUM,  1'b1, 8'h40, 24'hB00000, 1'b0, "R9");
        run(C_ZERO, 1'b1, 8'h00, 24'h000000, C_NUM,  1'b0, 8'h50, 24'hC00000, 1'b0, "R9");
        // R9: subtract flips b sign in result and pair
        run(C_NUM,  1'b0, 8'h60, 24'h900000, C_INF,  1'b0, 8'h70, 24'h800000, 1'b1, "R9");
        run(C_NUM,  1'b0, 8'h61, 24'h900001, C_QNAN, 1'b1, 8'h71, 24'hC00002, 1'b1, "R9");

        // Random sweep of class pairs
        for (int k = 0; k < 400; k++) begin
            run(codes[$urandom % 5], 1'($urandom), EXP_W'($urandom), MANT_W'($urandom) | 24'h800000,
                codes[$urandom % 5], 1'($urandom), EXP_W'($urandom), MANT_W'($urandom) | 24'h800000,
                1'($urandom), "R9");
        end

        // R2: out_valid drops after an idle cycle
        @(negedge clk);
        check("R2", {{(OP_W-1){1'b0}}, out_valid}, '0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule